// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces the column address sequence that a synchronous DRAM bank walks through during one read or write burst. A start strobe captures a starting column together with a length code and a wrap-order select. From the next rising edge on, the block presents one registered column address per clock, together with a valid flag and a flag that marks the final beat.

Two wrap orders are supported. In the linear order, the address counts upward inside an aligned window whose size is the burst length. In the interleaved order, the low address bits are the starting bits XORed with the beat number. A full-page length walks the whole column space and never reports a final beat. A full-page burst runs until a stop request or a new start arrives. A new start is accepted on any cycle and replaces the running burst at once, with no spacing rule between commands. An interleaved full-page request is not a legal combination. The block runs it as a linear full-page burst and raises an error flag that stays set until reset.

Top module: `sdram_burst_colgen`

## Requirements
- R1: After reset, `col_valid`, `col_last` and `cfg_err` are 0 and `col_addr` is 0.
- R2: When `start` is high at a rising edge, `col_addr` equals `start_col` and `col_valid` is 1 after that edge (beat 0).
- R3: The length code `cfg_len` selects the burst length: 0 gives 1 beat, 1 gives 2, 2 gives 4, 3 gives 8, and any code from 4 to 7 gives full page. A burst of N beats shows `col_valid` high for exactly N consecutive cycles, with `col_last` high only on beat N-1. `col_valid` falls on the following cycle.
- R4: With `cfg_ilv`=0 and length N, beat k carries the address (S - S mod N) + ((S mod N + k) mod N), where S is the start column.
- R5: With `cfg_ilv`=1 and length N of 1, 2, 4 or 8, beat k carries the address (S - S mod N) + ((S mod N) XOR k).
- R6: In full-page mode, beat k carries the address (S + k) mod 2^COL_W. `col_last` stays 0 and `col_valid` stays 1 until a stop or a new start.
- R7: When `stop` is high and `start` is low at an edge, `col_valid` and `col_last` are 0 after it, and `col_addr` holds its previous value.
- R8: A start that arrives on any beat of a running burst replaces that burst on the next edge. A start also takes priority over a stop presented at the same edge.
- R9: An interleaved full-page request (`cfg_ilv`=1 with length code 4 to 7) runs as a linear full-page burst and sets `cfg_err`. `cfg_err` then stays 1 until reset.
- R10: `cfg_len` and `cfg_ilv` are sampled only when `start` is high. Changing them during a burst has no effect on that burst.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_len | input | 3 | Burst length code |
| cfg_ilv | input | 1 | Wrap order: 0 linear, 1 interleaved |
| start | input | 1 | Begin a new burst at `start_col` |
| start_col | input | COL_W | Starting column |
| stop | input | 1 | End the current burst |
| col_addr | output | COL_W | Registered column address |
| col_valid | output | 1 | A burst beat is present on `col_addr` |
| col_last | output | 1 | Present beat is the final one |
| cfg_err | output | 1 | Sticky flag for an illegal length/order combination |

## Verification
A wrong beat counter shows up within one cycle as a wrong address, or as a final-beat flag on the wrong beat. Every beat of every burst is therefore compared against the arithmetic formula for its length, order and start. This is done for aligned and unaligned starts near both ends of the column space. A faulty latched configuration or base column stays hidden until the second beat. The stop and restart sweeps cover every beat position of an 8-beat burst, so stale state after an interruption is seen on the first replacement beat. A missing wrap shows at the window boundary or at the top of the column space. The checks cover the pass across that boundary in each case.

// File: rtl/sbc_pkg.sv
package sbc_pkg;

  localparam int LEN_CODE_W = 3;

  typedef enum logic {
    ORDER_LINEAR = 1'b0,
    ORDER_XOR    = 1'b1
  } wrap_order_e;

  // Column for a given beat: bits outside the window mask come from base,
  // bits inside come from either a wrapped sum or an XOR with the beat.
  function automatic logic [31:0] beat_column(input logic [31:0] base,
                                              input logic [31:0] beat,
                                              input logic [31:0] win_mask,
                                              input wrap_order_e order);
    logic [31:0] inner;
    inner = (order == ORDER_XOR) ? (base ^ beat) : (base + beat);
    return (base & ~win_mask) | (inner & win_mask);
  endfunction

endpackage

// File: rtl/sbc_cfg_decode.sv
module sbc_cfg_decode
  import sbc_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic [LEN_CODE_W-1:0] len_code,
  input  logic                  ilv_req,
  output logic [COL_W-1:0]      win_mask,
  output logic                  full_page,
  output wrap_order_e           order,
  output logic                  illegal
);

  always_comb begin
    full_page = 1'b0;
    unique case (len_code)
      3'd0:    win_mask = COL_W'(0);
      3'd1:    win_mask = COL_W'(1);
      3'd2:    win_mask = COL_W'(3);
      3'd3:    win_mask = COL_W'(7);
      default: begin
        win_mask  = '1;
        full_page = 1'b1;
      end
    endcase
    illegal = full_page & ilv_req;
    order   = (ilv_req & ~full_page) ? ORDER_XOR : ORDER_LINEAR;
  end

endmodule

// File: rtl/sbc_beat_ctrl.sv
module sbc_beat_ctrl #(
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             halt,
  input  logic [COL_W-1:0] win_mask,
  input  logic             full_page,
  output logic             valid,
  output logic             last,
  output logic             advance,
  output logic [COL_W-1:0] beat_nxt,
  output logic [COL_W-1:0] mask_q,
  output logic             full_q
);

  logic [COL_W-1:0] beat_q;

  assign advance  = valid & ~last & ~load & ~halt;
  assign beat_nxt = beat_q + COL_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid  <= 1'b0;
      last   <= 1'b0;
      beat_q <= '0;
      mask_q <= '0;
      full_q <= 1'b0;
    end else if (load) begin
      valid  <= 1'b1;
      beat_q <= '0;
      mask_q <= win_mask;
      full_q <= full_page;
      last   <= ~full_page & (win_mask == '0);
    end else if (halt) begin
      valid <= 1'b0;
      last  <= 1'b0;
    end else if (valid) begin
      if (last) begin
        valid <= 1'b0;
        last  <= 1'b0;
      end else begin
        beat_q <= beat_nxt;
        last   <= ~full_q & (beat_nxt == mask_q);
      end
    end
  end

endmodule

// File: rtl/sbc_addr_gen.sv
module sbc_addr_gen
  import sbc_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [COL_W-1:0] start_col,
  input  wrap_order_e      order,
  input  logic             advance,
  input  logic [COL_W-1:0] beat_nxt,
  input  logic [COL_W-1:0] mask_q,
  output logic [COL_W-1:0] col_addr,
  output wrap_order_e      order_q
);

  logic [COL_W-1:0] base_q;
  logic [31:0]      next_full;

  assign next_full = beat_column(32'(base_q), 32'(beat_nxt), 32'(mask_q), order_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q   <= '0;
      order_q  <= ORDER_LINEAR;
      col_addr <= '0;
    end else if (load) begin
      base_q   <= start_col;
      order_q  <= order;
      col_addr <= start_col;
    end else if (advance) begin
      col_addr <= next_full[COL_W-1:0];
    end
  end

endmodule

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen
  import sbc_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [LEN_CODE_W-1:0] cfg_len,
  input  logic                  cfg_ilv,
  input  logic                  start,
  input  logic [COL_W-1:0]      start_col,
  input  logic                  stop,
  output logic [COL_W-1:0]      col_addr,
  output logic                  col_valid,
  output logic                  col_last,
  output logic                  cfg_err
);

  logic [COL_W-1:0] win_mask;
  logic             full_page;
  wrap_order_e      order;
  logic             illegal;
  logic             advance;
  logic [COL_W-1:0] beat_nxt;
  logic [COL_W-1:0] mask_q;
  logic             full_q;
  wrap_order_e      order_q;

  // Named events for the checker
  logic load_evt;
  logic halt_evt;
  assign load_evt = start;
  assign halt_evt = stop & ~start;

  sbc_cfg_decode #(.COL_W(COL_W)) u_dec (
    .len_code (cfg_len),
    .ilv_req  (cfg_ilv),
    .win_mask (win_mask),
    .full_page(full_page),
    .order    (order),
    .illegal  (illegal)
  );

  sbc_beat_ctrl #(.COL_W(COL_W)) u_beat (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load_evt),
    .halt     (halt_evt),
    .win_mask (win_mask),
    .full_page(full_page),
    .valid    (col_valid),
    .last     (col_last),
    .advance  (advance),
    .beat_nxt (beat_nxt),
    .mask_q   (mask_q),
    .full_q   (full_q)
  );

  sbc_addr_gen #(.COL_W(COL_W)) u_addr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load_evt),
    .start_col(start_col),
    .order    (order),
    .advance  (advance),
    .beat_nxt (beat_nxt),
    .mask_q   (mask_q),
    .col_addr (col_addr),
    .order_q  (order_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)                 cfg_err <= 1'b0;
    else if (load_evt & illegal) cfg_err <= 1'b1;
  end

endmodule

// File: rtl/sbc_checker.sv
module sbc_checker
  import sbc_pkg::*;
#(
  parameter int COL_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [COL_W-1:0] start_col,
  input logic             stop,
  input logic [COL_W-1:0] col_addr,
  input logic             col_valid,
  input logic             col_last,
  input logic             cfg_err,
  input logic             full_mode,
  input wrap_order_e      order_q,
  input logic             advance
);

  a_r1_last_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    col_last |-> col_valid);

  a_r2_load_addr: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (col_valid && col_addr == $past(start_col)));

  a_r3_end_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (col_valid && col_last && !start) |=> !col_valid);

  a_r4_linear_full_step: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && full_mode) |=> (col_addr == $past(col_addr) + COL_W'(1)));

  a_r6_full_never_last: assert property (@(posedge clk) disable iff (!rst_n)
    full_mode |-> !col_last);

  a_r7_stop_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && !start) |=> (!col_valid && !col_last && $stable(col_addr)));

  a_r8_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!col_valid && !start) |=> (!col_valid && $stable(col_addr)));

  a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> cfg_err);

  a_r9_full_is_linear: assert property (@(posedge clk) disable iff (!rst_n)
    (col_valid && full_mode) |-> (order_q == ORDER_LINEAR));

endmodule

bind sdram_burst_colgen sbc_checker #(.COL_W(COL_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .start_col(start_col),
  .stop     (stop),
  .col_addr (col_addr),
  .col_valid(col_valid),
  .col_last (col_last),
  .cfg_err  (cfg_err),
  .full_mode(full_q),
  .order_q  (order_q),
  .advance  (advance)
);

// File: tb/sdram_burst_colgen_test.sv
module sdram_burst_colgen_test;

  localparam int COL_W = 10;
  localparam int NCOL  = 1 << COL_W;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [2:0]       cfg_len = '0;
  logic             cfg_ilv = 1'b0;
  logic             start = 1'b0;
  logic [COL_W-1:0] start_col = '0;
  logic             stop = 1'b0;
  logic [COL_W-1:0] col_addr;
  logic             col_valid;
  logic             col_last;
  logic             cfg_err;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  sdram_burst_colgen #(.COL_W(COL_W)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_len(cfg_len), .cfg_ilv(cfg_ilv),
    .start(start), .start_col(start_col), .stop(stop),
    .col_addr(col_addr), .col_valid(col_valid), .col_last(col_last),
    .cfg_err(cfg_err)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Expected column for beat k of an n-beat burst from s
  function automatic int exp_col(input int s, input int n, input int k, input bit ilv);
    int lo;
    int base;
    lo   = s % n;
    base = s - lo;
    if (ilv) return base + (lo ^ k);
    return base + ((lo + k) % n);
  endfunction

  task automatic do_reset();
    start = 0; stop = 0; rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  // Returns at the negedge where beat 0 is visible
  task automatic launch(input int lc, input bit ilv, input int col);
    @(negedge clk);
    cfg_len = 3'(lc); cfg_ilv = ilv; start_col = COL_W'(col); start = 1;
    @(negedge clk);
    start = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 valid", col_valid, 0);
    chk("R1 last", col_last, 0);
    chk("R1 err", cfg_err, 0);
    chk("R1 addr", col_addr, 0);

    // R2 R3 R4 R5 sweep over lengths, orders and starts
    for (int lc = 0; lc < 4; lc++) begin
      for (int ilv = 0; ilv < 2; ilv++) begin
        for (int si = 0; si < 32; si++) begin
          int n;
          int s;
          n = 1 << lc;
          s = (si < 16) ? si : (NCOL - 32 + si);
          launch(lc, 1'(ilv), s);
          for (int k = 0; k < n; k++) begin
            chk(ilv ? "R5 addr" : "R4 addr", col_addr, exp_col(s, n, k, 1'(ilv)));
            chk("R2 R3 valid", col_valid, 1);
            chk("R3 last", col_last, (k == n - 1) ? 1 : 0);
            if (k < n - 1) @(negedge clk);
          end
          @(negedge clk);
          chk("R3 end valid", col_valid, 0);
        end
      end
    end

    // R6 full page wraps across top of the column space
    launch(4, 0, NCOL - 4);
    for (int k = 0; k < 12; k++) begin
      chk("R6 addr", col_addr, (NCOL - 4 + k) % NCOL);
      chk("R6 valid", col_valid, 1);
      chk("R6 last", col_last, 0);
      @(negedge clk);
    end
    chk("R9 no err on legal", cfg_err, 0);
    stop = 1; @(negedge clk); stop = 0;
    chk("R7 full stop", col_valid, 0);

    // R7 stop at every beat position
    for (int p = 0; p < 8; p++) begin
      int held;
      launch(3, 1, 3);
      for (int k = 0; k < p; k++) @(negedge clk);
      held = exp_col(3, 8, p, 1);
      chk("R7 pre addr", col_addr, held);
      stop = 1; @(negedge clk); stop = 0;
      chk("R7 valid", col_valid, 0);
      chk("R7 last", col_last, 0);
      chk("R7 hold", col_addr, held);
      @(negedge clk);
      chk("R7 still idle", col_valid, 0);
      chk("R7 still hold", col_addr, held);
    end

    // R8 restart at every beat position, with stop on odd positions
    for (int p = 0; p < 8; p++) begin
      int s2;
      launch(3, 0, 10);
      for (int k = 0; k < p; k++) @(negedge clk);
      s2 = 700 + p;
      cfg_len = 3'd2; cfg_ilv = 1; start_col = COL_W'(s2); start = 1; stop = p[0];
      @(negedge clk);
      start = 0; stop = 0;
      for (int k = 0; k < 4; k++) begin
        chk("R8 addr", col_addr, exp_col(s2, 4, k, 1));
        chk("R8 valid", col_valid, 1);
        chk("R8 last", col_last, (k == 3) ? 1 : 0);
        @(negedge clk);
      end
      chk("R8 end", col_valid, 0);
    end

    // R10 config change during a burst is ignored
    launch(2, 0, 6);
    cfg_len = 3'd3; cfg_ilv = 1;
    for (int k = 0; k < 4; k++) begin
      chk("R10 addr", col_addr, exp_col(6, 4, k, 0));
      chk("R10 last", col_last, (k == 3) ? 1 : 0);
      @(negedge clk);
    end
    chk("R10 end", col_valid, 0);

    // R9 illegal interleaved full page
    launch(7, 1, 5);
    chk("R9 err set", cfg_err, 1);
    for (int k = 0; k < 6; k++) begin
      chk("R9 linear addr", col_addr, 5 + k);
      chk("R9 last", col_last, 0);
      @(negedge clk);
    end
    stop = 1; @(negedge clk); stop = 0;
    launch(1, 0, 2);
    chk("R9 sticky", cfg_err, 1);
    do_reset();
    chk("R9 R1 cleared", cfg_err, 0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule